// File: doc/BRIEF.md
# External request pause/start gate

This block decides, cycle by cycle, whether a DMA channel may move data when its pacing is tied to an external, active-low request pin. The data path and the descriptor walker sit outside; they read `xfer_en_o` as the permission to issue beats and report every accepted beat with its byte count.

Two independent options shape the gate. With delegated start enabled, a software start only arms the channel, and the first beat waits for a falling edge on the request pin. With metered pause enabled, the gate counts bytes from the start and pauses the channel once a power-of-two quantum has been moved. It resumes only on a new falling edge of the pin and counts the next quantum from zero. An abort returns the gate to idle from any state.

Top module: `ext_req_gate`

## Requirements
- R1: After reset `xfer_en_o` and `paused_o` are both 0.
- R2: With delegated start off, a `sw_start_i` pulse in idle sets `xfer_en_o` to 1 on the clock edge that samples it.
- R3: With delegated start on, a `sw_start_i` pulse only arms the channel and `xfer_en_o` stays 0. The channel starts after a falling edge on `req_ni`: the pin passes two synchroniser flops and one edge register, so `xfer_en_o` rises on the third rising clock edge after the pin goes low.
- R4: The quantum is 2 to the power of `quantum_log2_i`, and values above 10 give 1024 bytes. With metered pause on, the beat that brings the byte count to the quantum or past it moves the gate to paused on its clock edge: `xfer_en_o` drops to 0 and `paused_o` rises to 1.
- R5: When a beat crosses the quantum boundary, the pause is taken after that beat completes. The excess is not carried, so after a resume a full quantum is counted again from zero.
- R6: A paused gate resumes only on a new falling edge of `req_ni`, with the same three-edge latency as R3. A pin held low, or a rising edge, leaves it paused.
- R7: A falling edge on `req_ni` while idle or running has no effect on the outputs.
- R8: `abort_i` clears the armed, running, paused and counting state on the edge that samples it. It takes priority over a start and over a pin edge in the same cycle.
- R9: With metered pause off, no number of bytes ever pauses the gate.
- R10: `xfer_en_o` and `paused_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_start_en_i | input | 1 | Delegate the start to the request pin |
| ext_pause_en_i | input | 1 | Enable metered pause after each quantum |
| quantum_log2_i | input | 4 | Base-2 logarithm of the pause quantum in bytes |
| sw_start_i | input | 1 | Software start pulse |
| abort_i | input | 1 | Abort pulse, returns the gate to idle |
| beat_valid_i | input | 1 | A beat was accepted this cycle |
| beat_bytes_i | input | 5 | Byte count of the accepted beat |
| req_ni | input | 1 | Asynchronous request pin, active low |
| xfer_en_o | output | 1 | The channel may move data |
| paused_o | output | 1 | The channel is paused, waiting for a request edge |

## Verification
The assertions take for granted that `sw_start_i` and `abort_i` are single-cycle pulses, and that the mode inputs and `quantum_log2_i` stay unchanged while the gate is away from idle. The stimulus changes the modes only after an abort has returned the gate to idle. After each level change it keeps the request pin steady for at least three cycles, so that every falling edge reaches the edge register as a clean transition. Beats are also offered while the gate is paused, and the outputs must stay the same.

// File: rtl/ext_req_gate_pkg.sv
package ext_req_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_PAUSE = 2'd3
  } gate_state_e;
endpackage

// File: rtl/req_edge_sync.sv
module req_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic fall_o
);
  // q[STAGES] is the edge-detect register behind the synchroniser
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= ~req_ni;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= q[i-1];
    end
  end

  assign fall_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/quantum_counter.sv
module quantum_counter #(
  parameter int MAX_LOG2 = 10,
  parameter int LOG2_W   = 4,
  parameter int BEAT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              count_i,
  input  logic [BEAT_W-1:0] bytes_i,
  input  logic [LOG2_W-1:0] log2_i,
  output logic              reached_o
);
  localparam int CNT_W = MAX_LOG2 + 1;
  localparam int SUM_W = CNT_W + 1;

  logic [LOG2_W-1:0] log2_c;
  logic [CNT_W-1:0]  quantum;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W-1:0]  sum;

  assign log2_c  = (log2_i > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : log2_i;
  assign quantum = CNT_W'(1) << log2_c;
  assign sum     = SUM_W'(cnt_q) + SUM_W'(bytes_i);

  assign reached_o = count_i && (sum >= SUM_W'(quantum));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (reached_o) cnt_q <= quantum;
    else if (count_i)   cnt_q <= sum[CNT_W-1:0];
  end

  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i && !clear_i) |=> (cnt_q <= $past(quantum)));
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import ext_req_gate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_start_en_i,
  input  logic        ext_pause_en_i,
  input  logic        sw_start_i,
  input  logic        abort_i,
  input  logic        beat_valid_i,
  input  logic        fall_i,
  input  logic        reached_i,
  output logic        cnt_clear_o,
  output logic        cnt_en_o,
  output gate_state_e state_o
);
  gate_state_e st_q, st_d;

  assign cnt_en_o = (st_q == ST_RUN) && beat_valid_i && ext_pause_en_i;

  always_comb begin
    st_d        = st_q;
    cnt_clear_o = 1'b0;
    if (abort_i) begin
      st_d        = ST_IDLE;
      cnt_clear_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (sw_start_i) begin
          st_d        = ext_start_en_i ? ST_ARMED : ST_RUN;
          cnt_clear_o = 1'b1;
        end
        ST_ARMED: if (fall_i) begin
          st_d        = ST_RUN;
          cnt_clear_o = 1'b1;
        end
        ST_RUN: if (cnt_en_o && reached_i) st_d = ST_PAUSE;
        ST_PAUSE: if (fall_i) begin
          st_d        = ST_RUN;
          cnt_clear_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  // R8
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (st_q == ST_IDLE));
  // R2
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sw_start_i && !ext_start_en_i && !abort_i) |=> (st_q == ST_RUN));
  // R3
  armed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !fall_i && !abort_i) |=> (st_q == ST_ARMED));
  // R6
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE && !fall_i && !abort_i) |=> (st_q == ST_PAUSE));
  // R9
  no_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !ext_pause_en_i) |=> (st_q != ST_PAUSE));
endmodule

// File: rtl/ext_req_gate.sv
module ext_req_gate
  import ext_req_gate_pkg::*;
#(
  parameter int MAX_LOG2    = 10,
  parameter int LOG2_W      = 4,
  parameter int BEAT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_start_en_i,
  input  logic              ext_pause_en_i,
  input  logic [LOG2_W-1:0] quantum_log2_i,
  input  logic              sw_start_i,
  input  logic              abort_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  logic              req_ni,
  output logic              xfer_en_o,
  output logic              paused_o
);
  logic        req_fall;
  logic        reached;
  logic        cnt_clear;
  logic        cnt_en;
  gate_state_e state;

  req_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .fall_o (req_fall)
  );

  quantum_counter #(.MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W), .BEAT_W(BEAT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cnt_clear),
    .count_i   (cnt_en),
    .bytes_i   (beat_bytes_i),
    .log2_i    (quantum_log2_i),
    .reached_o (reached)
  );

  gate_fsm i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ext_start_en_i (ext_start_en_i),
    .ext_pause_en_i (ext_pause_en_i),
    .sw_start_i     (sw_start_i),
    .abort_i        (abort_i),
    .beat_valid_i   (beat_valid_i),
    .fall_i         (req_fall),
    .reached_i      (reached),
    .cnt_clear_o    (cnt_clear),
    .cnt_en_o       (cnt_en),
    .state_o        (state)
  );

  assign xfer_en_o = (state == ST_RUN);
  assign paused_o  = (state == ST_PAUSE);

  // R10
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_en_o && paused_o));
endmodule

// File: tb/test_ext_req_gate.sv
module test_ext_req_gate;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_start_en = 1'b0, ext_pause_en = 1'b0;
  logic [3:0] log2 = 4'd2;
  logic       sw_start = 1'b0, abort = 1'b0, beat_valid = 1'b0;
  logic [4:0] beat_bytes = '0;
  logic       req_n = 1'b1;
  logic       xfer_en, paused;

  // settings applied at the next tick
  logic       req_set = 1'b1, es_set = 1'b0, ep_set = 1'b0;
  logic [3:0] lg_set = 4'd2;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  ext_req_gate i_ext_req_gate (
    .clk_i(clk), .rst_ni(rst_ni), .ext_start_en_i(ext_start_en),
    .ext_pause_en_i(ext_pause_en), .quantum_log2_i(log2),
    .sw_start_i(sw_start), .abort_i(abort), .beat_valid_i(beat_valid),
    .beat_bytes_i(beat_bytes), .req_ni(req_n),
    .xfer_en_o(xfer_en), .paused_o(paused)
  );

  task automatic tick(input logic sw, input logic ab, input logic bv,
                      input logic [4:0] nb, input logic ex, input logic ep,
                      input string tag);
    @(negedge clk);
    sw_start = sw; abort = ab; beat_valid = bv; beat_bytes = nb;
    req_n = req_set; ext_start_en = es_set; ext_pause_en = ep_set; log2 = lg_set;
    exp_q.push_back({ex, ep});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input logic ex, input logic ep, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 5'd0, ex, ep, tag);
  endtask

  // monitor: compares after each rising edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({xfer_en, paused} !== e) begin
          fails++;
          $display("FAIL %s: xfer_en=%0b paused=%0b expected xfer_en=%0b paused=%0b",
                   t, xfer_en, paused, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2, 1'b0, 1'b0, "R1 reset");

    // plain start, no metering
    tick(1, 0, 0, 0, 1, 0, "R2 start");
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 5'd16, 1, 0, "R9 no pause");
    req_set = 1'b0; idle(4, 1, 0, "R7 edge while running");
    req_set = 1'b1; idle(3, 1, 0, "R7 running");
    tick(0, 1, 0, 0, 0, 0, "R8 abort run");

    // edge while idle, delegated start selected
    es_set = 1'b1;
    idle(3, 0, 0, "R7 idle");
    req_set = 1'b0; idle(4, 0, 0, "R7 edge while idle");
    req_set = 1'b1; idle(3, 0, 0, "R7 idle");

    // delegated start
    tick(1, 0, 0, 0, 0, 0, "R3 armed");
    idle(2, 0, 0, "R3 armed hold");
    req_set = 1'b0;
    idle(2, 0, 0, "R3 sync delay");
    idle(1, 1, 0, "R3 pin start");
    req_set = 1'b1; idle(3, 1, 0, "R3 running");
    tick(0, 1, 0, 0, 0, 0, "R8 abort");

    // metered pause, quantum 4
    es_set = 1'b0; ep_set = 1'b1; lg_set = 4'd2;
    idle(1, 0, 0, "R8 idle");
    tick(1, 0, 0, 0, 1, 0, "R2 start metered");
    tick(0, 0, 1, 5'd1, 1, 0, "R4 count 1");
    tick(0, 0, 1, 5'd2, 1, 0, "R4 count 3");
    tick(0, 0, 1, 5'd1, 0, 1, "R4 quantum pause");
    tick(0, 0, 1, 5'd8, 0, 1, "R4 beat while paused");
    req_set = 1'b0;
    idle(2, 0, 1, "R6 sync delay");
    idle(1, 1, 0, "R6 resume");
    tick(0, 0, 1, 5'd4, 0, 1, "R4 full quantum beat");
    idle(4, 0, 1, "R6 held low");
    req_set = 1'b1; idle(3, 0, 1, "R6 rising edge");
    req_set = 1'b0;
    idle(2, 0, 1, "R6 sync delay");
    idle(1, 1, 0, "R6 resume 2");
    tick(0, 0, 1, 5'd3, 1, 0, "R5 count 3");
    tick(0, 0, 1, 5'd3, 0, 1, "R5 crossing beat");
    req_set = 1'b1; idle(3, 0, 1, "R6 paused");
    req_set = 1'b0;
    idle(2, 0, 1, "R6 sync delay");
    idle(1, 1, 0, "R6 resume 3");
    tick(0, 0, 1, 5'd3, 1, 0, "R5 no carry");
    tick(0, 0, 1, 5'd1, 0, 1, "R5 fresh quantum");
    tick(0, 1, 0, 0, 0, 0, "R8 abort paused");
    tick(1, 1, 0, 0, 0, 0, "R8 abort beats start");
    idle(2, 0, 0, "R8 idle");

    // clamped quantum of 1024
    req_set = 1'b1; lg_set = 4'd15;
    idle(3, 0, 0, "R8 idle");
    tick(1, 0, 0, 0, 1, 0, "R2 start");
    for (int i = 0; i < 63; i++) tick(0, 0, 1, 5'd16, 1, 0, "R4 below 1024");
    tick(0, 0, 1, 5'd16, 0, 1, "R4 clamp 1024");
    tick(0, 1, 0, 0, 0, 0, "R8 abort");

    // quantum of 1
    lg_set = 4'd0;
    idle(1, 0, 0, "R8 idle");
    tick(1, 0, 0, 0, 1, 0, "R2 start");
    tick(0, 0, 1, 5'd1, 0, 1, "R4 quantum 1");
    tick(0, 1, 0, 0, 0, 0, "R8 abort");

    idle(1, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule